// File: doc/BRIEF.md
# Low-Frequency Real-Time Counter

This block is a 24-bit real-time counter that advances on a slow clock. The slow clock is delivered as a single-cycle enable, `slow_tick`, in the fast system clock domain. A 12-bit divider sits in front of the counter, so the count rate is the tick rate divided by (divider value + 1). Four compare channels watch the count. The block raises sticky event flags for every increment, for a wrap from all-ones to zero, and for each compare hit. The interrupt line is the OR of the flags that are enabled for interrupt.

Software drives the block through a word-addressed register port. A write is a one-cycle `bus_we` strobe, and the read data follows `bus_addr` combinationally. Writes to some addresses are commands: run, halt, zero the count, or jump to 0xFFFFF0 so that wrap handling can be tested without a long wait. Interrupt enables and the routing enables each have a separate set address and clear address. When an event fires and its routing enable is set, the matching `evt_route` bit gives a one-cycle pulse, which can trigger other blocks. There is no streaming data path, so every pin is plain control or status.

Top module: `lfrtc_top`

## Requirements
- R1: After reset the count, divider value, divider phase, compare values, flags, interrupt enables and routing enables are all zero, the counter is halted, and `irq` and `evt_route` are low.
- R2: A write to address 0 starts the counter and a write to address 1 halts it. While running, an increment happens on a `slow_tick` cycle when the divider phase is at or above the divider value. That cycle resets the phase to 0; any other `slow_tick` cycle while running adds 1 to the phase. While halted the count does not change. The running state in force before a start or halt write governs that same cycle.
- R3: A write to address 17 loads bits 11:0 of the write data into the divider value only while the counter is halted. While running the write is ignored. Reading address 17 returns the divider value.
- R4: A write to address 2 zeroes the count and the divider phase. A write to address 3 loads 0xFFFFF0 and zeroes the phase. Neither command raises an event, and either one overrides an increment in the same cycle.
- R5: Flag bit 0 (tick) sets on every increment.
- R6: Flag bit 1 (overflow) sets on the increment from 0xFFFFFF to 0.
- R7: Flag bit 2+n sets when an increment produces a count equal to compare value n. Compare value n is written and read at address 20+n, bits 23:0. Loads, clears and compare writes never set it.
- R8: Flags are sticky. Writing zero to address 8+k clears flag k, and a nonzero write there has no effect. If an event sets a flag in the same cycle that its clear is written, the flag stays set. Reading address 8+k returns flag k in bit 0.
- R9: At address 4, write-one bits set interrupt enables; at address 5, write-one bits clear them. Bits 5:0 follow the flag order, and reading either address returns the enables. `irq` is high exactly when some flag and its enable are both set.
- R10: Addresses 6 and 7 set and clear the routing enables in the same way, and reading either returns them. `evt_route[k]` is high for one cycle, on the cycle after event k fires, when routing enable k was set in the firing cycle.
- R11: Address 16 reads the count. Unmapped addresses and command addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable at the slow clock rate |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_flags | output | 6 | Sticky flags: tick, overflow, compare 0..3 |
| evt_route | output | 6 | One-cycle routed event pulses |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. A zero or near-wrap command can land on the cycle where the divider would advance the count, and a flag-clear write can land on the cycle where that flag's event fires. The bench provokes both on purpose: it issues the command or the clear together with `slow_tick` while the divider value is 0. A behavioural reference model, updated every cycle, judges the result. In the command case the model expects the loaded value and no tick flag; in the clear case it expects the flag to stay set. A long random phase then mixes commands, clears and ticks and compares the model against the design on every clock.

// File: rtl/lfrtc_pkg.sv
package lfrtc_pkg;
  // flag ordering
  localparam int EV_TICK = 0;
  localparam int EV_OVF  = 1;
  localparam int EV_CMP0 = 2;

  // word addresses
  localparam int A_START  = 0;
  localparam int A_HALT   = 1;
  localparam int A_ZERO   = 2;
  localparam int A_NEAR   = 3;
  localparam int A_INTSET = 4;
  localparam int A_INTCLR = 5;
  localparam int A_RTESET = 6;
  localparam int A_RTECLR = 7;
  localparam int A_FLAG0  = 8;
  localparam int A_COUNT  = 16;
  localparam int A_DIV    = 17;
  localparam int A_CMP0   = 20;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_ZERO = 2'd1,
    LD_NEAR = 2'd2
  } load_e;
endpackage

// File: rtl/lfrtc_prescale.sv
module lfrtc_prescale #(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             start,
  input  logic             halt,
  input  logic             restart,
  input  logic             div_we,
  input  logic [PSC_W-1:0] div_wdata,
  output logic             running,
  output logic [PSC_W-1:0] div_val,
  output logic             inc
);
  logic [PSC_W-1:0] phase_q;
  logic             run_q;
  logic [PSC_W-1:0] div_q;
  logic             at_end;

  assign at_end  = (phase_q >= div_q);
  assign inc     = run_q && slow_tick && at_end && !restart;
  assign running = run_q;
  assign div_val = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
    end else if (halt) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_we && !run_q) begin
      div_q <= div_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run_q && slow_tick) begin
      phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/lfrtc_counter.sv
module lfrtc_counter
  import lfrtc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int N_CMP = 4,
  localparam int NEV  = 2 + N_CMP
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc,
  input  load_e                       load,
  input  logic [N_CMP-1:0]            cmp_we,
  input  logic [CNT_W-1:0]            cmp_wdata,
  output logic [CNT_W-1:0]            count,
  output logic [N_CMP-1:0][CNT_W-1:0] cmp_val,
  output logic [NEV-1:0]              ev
);
  localparam logic [CNT_W-1:0] NEAR_VAL = {CNT_W{1'b1}} << 4;
  localparam logic [CNT_W-1:0] MAX_VAL  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = cnt_q + 1'b1;
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (load)
        LD_ZERO: cnt_q <= '0;
        LD_NEAR: cnt_q <= NEAR_VAL;
        default: if (inc) cnt_q <= cnt_next;
      endcase
    end
  end

  assign ev[EV_TICK] = inc;
  assign ev[EV_OVF]  = inc && (cnt_q == MAX_VAL);

  for (genvar n = 0; n < N_CMP; n++) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (cmp_we[n]) begin
        cmp_q <= cmp_wdata;
      end
    end
    assign cmp_val[n]      = cmp_q;
    assign ev[EV_CMP0 + n] = inc && (cnt_next == cmp_q);
  end
endmodule

// File: rtl/lfrtc_events.sv
module lfrtc_events #(
  parameter int NEV = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] flag_clr,
  input  logic [NEV-1:0] int_set,
  input  logic [NEV-1:0] int_clr,
  input  logic [NEV-1:0] rte_set,
  input  logic [NEV-1:0] rte_clr,
  output logic [NEV-1:0] flags,
  output logic [NEV-1:0] int_en,
  output logic [NEV-1:0] rte_en,
  output logic [NEV-1:0] route,
  output logic           irq
);
  for (genvar k = 0; k < NEV; k++) begin : g_ev
    logic flag_q, ie_q, re_q, pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q  <= 1'b0;
        ie_q    <= 1'b0;
        re_q    <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        flag_q  <= ev[k] | (flag_q & ~flag_clr[k]);
        ie_q    <= int_set[k] | (ie_q & ~int_clr[k]);
        re_q    <= rte_set[k] | (re_q & ~rte_clr[k]);
        pulse_q <= ev[k] & re_q;
      end
    end

    assign flags[k]  = flag_q;
    assign int_en[k] = ie_q;
    assign rte_en[k] = re_q;
    assign route[k]  = pulse_q;
  end

  assign irq = |(flags & int_en);
endmodule

// File: rtl/lfrtc_top.sv
module lfrtc_top
  import lfrtc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PSC_W  = 12,
  parameter int N_CMP  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int NEV   = 2 + N_CMP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NEV-1:0]    evt_flags,
  output logic [NEV-1:0]    evt_route,
  output logic              irq
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  logic                        wr_start, wr_halt, ld_zero, ld_near, wr_div;
  logic                        run_q, inc_w;
  logic [PSC_W-1:0]            div_w;
  load_e                       load_w;
  logic [N_CMP-1:0]            cmp_we;
  logic [CNT_W-1:0]            count_w;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_w;
  logic [NEV-1:0]              ev_w, flag_clr;
  logic [NEV-1:0]              int_set, int_clr, rte_set, rte_clr;
  logic [NEV-1:0]              int_en_w, rte_w;

  assign wr_start = bus_we && hit(bus_addr, A_START);
  assign wr_halt  = bus_we && hit(bus_addr, A_HALT);
  assign ld_zero  = bus_we && hit(bus_addr, A_ZERO);
  assign ld_near  = bus_we && hit(bus_addr, A_NEAR);
  assign wr_div   = bus_we && hit(bus_addr, A_DIV);
  assign load_w   = ld_zero ? LD_ZERO : (ld_near ? LD_NEAR : LD_NONE);

  assign int_set = (bus_we && hit(bus_addr, A_INTSET)) ? bus_wdata[NEV-1:0] : '0;
  assign int_clr = (bus_we && hit(bus_addr, A_INTCLR)) ? bus_wdata[NEV-1:0] : '0;
  assign rte_set = (bus_we && hit(bus_addr, A_RTESET)) ? bus_wdata[NEV-1:0] : '0;
  assign rte_clr = (bus_we && hit(bus_addr, A_RTECLR)) ? bus_wdata[NEV-1:0] : '0;

  for (genvar k = 0; k < NEV; k++) begin : g_fclr
    assign flag_clr[k] = bus_we && hit(bus_addr, A_FLAG0 + k) && (bus_wdata == '0);
  end

  for (genvar n = 0; n < N_CMP; n++) begin : g_cwe
    assign cmp_we[n] = bus_we && hit(bus_addr, A_CMP0 + n);
  end

  lfrtc_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .start     (wr_start),
    .halt      (wr_halt),
    .restart   (ld_zero | ld_near),
    .div_we    (wr_div),
    .div_wdata (bus_wdata[PSC_W-1:0]),
    .running   (run_q),
    .div_val   (div_w),
    .inc       (inc_w)
  );

  lfrtc_counter #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (inc_w),
    .load      (load_w),
    .cmp_we    (cmp_we),
    .cmp_wdata (bus_wdata[CNT_W-1:0]),
    .count     (count_w),
    .cmp_val   (cmp_w),
    .ev        (ev_w)
  );

  lfrtc_events #(.NEV(NEV)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_w),
    .flag_clr (flag_clr),
    .int_set  (int_set),
    .int_clr  (int_clr),
    .rte_set  (rte_set),
    .rte_clr  (rte_clr),
    .flags    (evt_flags),
    .int_en   (int_en_w),
    .rte_en   (rte_w),
    .route    (evt_route),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, A_INTSET) || hit(bus_addr, A_INTCLR)) bus_rdata[NEV-1:0] = int_en_w;
    if (hit(bus_addr, A_RTESET) || hit(bus_addr, A_RTECLR)) bus_rdata[NEV-1:0] = rte_w;
    if (hit(bus_addr, A_COUNT)) bus_rdata[CNT_W-1:0] = count_w;
    if (hit(bus_addr, A_DIV))   bus_rdata[PSC_W-1:0] = div_w;
    for (int k = 0; k < NEV; k++) begin
      if (hit(bus_addr, A_FLAG0 + k)) bus_rdata[0] = evt_flags[k];
    end
    for (int n = 0; n < N_CMP; n++) begin
      if (hit(bus_addr, A_CMP0 + n)) bus_rdata[CNT_W-1:0] = cmp_w[n];
    end
  end
endmodule

// File: rtl/lfrtc_chk.sv
module lfrtc_chk #(
  parameter int CNT_W  = 24,
  parameter int PSC_W  = 12,
  parameter int NEV    = 6,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              inc_w,
  input logic              ld_zero,
  input logic              ld_near,
  input logic [CNT_W-1:0]  count_w,
  input logic [PSC_W-1:0]  div_w,
  input logic [NEV-1:0]    rte_w,
  input logic [NEV-1:0]    evt_flags,
  input logic [NEV-1:0]    evt_route,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  localparam logic [CNT_W-1:0] NEAR_VAL = {CNT_W{1'b1}} << 4;
  localparam logic [CNT_W-1:0] MAX_VAL  = {CNT_W{1'b1}};

  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ld_zero && !ld_near) |=> (count_w == $past(count_w)));

  // R3
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (div_w == $past(div_w)));

  // R4
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_zero |=> (count_w == '0) && !($rose(evt_flags[0])));

  // R4
  near_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_near && !ld_zero) |=> (count_w == NEAR_VAL));

  // R5
  tick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_w |=> evt_flags[0]);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_w && count_w == MAX_VAL) |=> (evt_flags[1] && count_w == '0));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flags[0] && !(bus_we && bus_addr == ADDR_W'(8) && bus_wdata == '0)) |=> evt_flags[0]);

  // R10
  route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_w && rte_w[0]) |=> evt_route[0]);
endmodule

bind lfrtc_top lfrtc_chk #(
  .CNT_W(CNT_W), .PSC_W(PSC_W), .NEV(NEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .inc_w     (inc_w),
  .ld_zero   (ld_zero),
  .ld_near   (ld_near),
  .count_w   (count_w),
  .div_w     (div_w),
  .rte_w     (rte_w),
  .evt_flags (evt_flags),
  .evt_route (evt_route),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_lfrtc_top.sv
`timescale 1ns/1ps
module tb_lfrtc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = 5'd16;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  evt_flags, evt_route;
  logic        irq;

  always #2.5 clk = ~clk;

  lfrtc_top dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_flags(evt_flags), .evt_route(evt_route), .irq(irq)
  );

  int    vecs = 0;
  int    miss = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_run;
  int          m_phase;
  logic [11:0] m_div;
  logic [23:0] m_cnt;
  logic [23:0] m_cmp [4];
  logic [5:0]  m_flags, m_ie, m_re, m_route;

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    logic [31:0] r = '0;
    case (a)
      5'd4, 5'd5: r[5:0] = m_ie;
      5'd6, 5'd7: r[5:0] = m_re;
      5'd16: r[23:0] = m_cnt;
      5'd17: r[11:0] = m_div;
      default: begin
        if (a >= 8 && a <= 13) r[0] = m_flags[a - 8];
        if (a >= 20 && a <= 23) r[23:0] = m_cmp[a - 20];
      end
    endcase
    return r;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit we, input logic [4:0] a, input logic [31:0] d, input bit tk);
    bit          ldz, ldn, inc;
    logic [5:0]  ev;
    logic [23:0] nxt;
    ldz = we && a == 2;
    ldn = we && a == 3;
    inc = m_run && tk && (m_phase >= int'(m_div)) && !ldz && !ldn;
    nxt = m_cnt + 24'd1;
    ev  = '0;
    ev[0] = inc;
    ev[1] = inc && (m_cnt == 24'hFFFFFF);
    for (int n = 0; n < 4; n++) ev[2+n] = inc && (nxt == m_cmp[n]);
    m_route = ev & m_re;
    if (we && a >= 8 && a <= 13 && d == 0) m_flags[a - 8] = 1'b0;
    m_flags = m_flags | ev;
    if (ldz || ldn) m_phase = 0;
    else if (m_run && tk) m_phase = (m_phase >= int'(m_div)) ? 0 : m_phase + 1;
    if (ldz) m_cnt = '0;
    else if (ldn) m_cnt = 24'hFFFFF0;
    else if (inc) m_cnt = nxt;
    if (we && a == 17 && !m_run) m_div = d[11:0];
    if (we && a >= 20 && a <= 23) m_cmp[a - 20] = d[23:0];
    if (we && a == 4) m_ie = m_ie | d[5:0];
    if (we && a == 5) m_ie = m_ie & ~d[5:0];
    if (we && a == 6) m_re = m_re | d[5:0];
    if (we && a == 7) m_re = m_re & ~d[5:0];
    if (we && a == 0) m_run = 1'b1;
    else if (we && a == 1) m_run = 1'b0;
  endtask

  // one cycle: drive at negedge, compare, advance model, wait for next negedge
  task automatic cyc(input bit we, input logic [4:0] a, input logic [31:0] d, input bit tk);
    bus_we = we; bus_addr = a; bus_wdata = d; slow_tick = tk;
    #1;
    vecs++;
    check("bus_rdata", bus_rdata, model_rd(a));
    check("evt_flags", {26'd0, evt_flags}, {26'd0, m_flags});
    check("evt_route", {26'd0, evt_route}, {26'd0, m_route});
    check("irq", {31'd0, irq}, {31'd0, |(m_flags & m_ie)});
    model_step(we, a, d, tk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int period);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'd16, 32'd0, (i % period) == 0);
  endtask

  initial begin
    m_run = 0; m_phase = 0; m_div = '0; m_cnt = '0;
    m_flags = '0; m_ie = '0; m_re = '0; m_route = '0;
    for (int n = 0; n < 4; n++) m_cmp[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    idle(3, 1);
    cyc(0, 5'd4, 0, 0); cyc(0, 5'd6, 0, 0); cyc(0, 5'd8, 0, 0);
    cyc(0, 5'd17, 0, 0); cyc(0, 5'd20, 0, 0);

    cur_req = "R3";
    cyc(1, 5'd17, 32'hFFFF_F003, 0); cyc(0, 5'd17, 0, 0);
    cyc(1, 5'd17, 32'h0000_0002, 0); cyc(0, 5'd17, 0, 0);

    cur_req = "R9";
    cyc(1, 5'd4, 32'h3F, 0); cyc(1, 5'd5, 32'h02, 0);
    cyc(0, 5'd4, 0, 0); cyc(0, 5'd5, 0, 0);

    cur_req = "R10";
    cyc(1, 5'd6, 32'h05, 0); cyc(0, 5'd7, 0, 0);

    cur_req = "R7";
    cyc(1, 5'd20, 32'h0000_0005, 0); cyc(1, 5'd21, 32'h0000_0000, 0);
    cyc(1, 5'd22, 32'h00FF_FFF2, 0); cyc(1, 5'd23, 32'hAB00_0003, 0);
    cyc(0, 5'd23, 0, 0);

    cur_req = "R2";
    cyc(1, 5'd0, 0, 0);
    idle(20, 2);
    cur_req = "R5";
    idle(20, 2);
    cur_req = "R3";
    cyc(1, 5'd17, 32'h0, 1); cyc(0, 5'd17, 0, 0);
    cur_req = "R2";
    cyc(1, 5'd1, 0, 1);
    idle(10, 1);

    cur_req = "R8";
    cyc(1, 5'd8, 32'h1, 0); cyc(0, 5'd8, 0, 0);
    cyc(1, 5'd8, 32'h0, 0); cyc(0, 5'd8, 0, 0);
    cyc(1, 5'd12, 32'h0, 0);

    cur_req = "R4";
    cyc(1, 5'd17, 32'h0, 0);
    cyc(1, 5'd3, 0, 1);
    cyc(1, 5'd0, 0, 0);
    cur_req = "R6";
    idle(20, 1);
    cur_req = "R4";
    cyc(1, 5'd8, 0, 0);
    cyc(1, 5'd2, 0, 1); cyc(0, 5'd16, 0, 0);
    cyc(1, 5'd3, 0, 1); cyc(0, 5'd8, 0, 0);

    cur_req = "R8";
    cyc(1, 5'd8, 0, 1); cyc(0, 5'd8, 0, 0);

    cur_req = "R10";
    cyc(1, 5'd7, 32'h3F, 0);
    idle(5, 1);

    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      bit          we = ($urandom_range(0, 3) == 0);
      logic [4:0]  a  = 5'($urandom_range(0, 23));
      logic [31:0] d  = ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom;
      if (!we && $urandom_range(0, 1) == 0) a = 5'd16;
      cyc(we, a, d, $urandom_range(0, 1) == 1);
    end
    for (int a = 0; a < 32; a++) cyc(0, 5'(a), 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule